// File: doc/BRIEF.md
# Synchronous Burst SRAM

A single-port synchronous static memory that can run short bursts on its own. A burst starts on a rising clock edge when one of two address strobes is active and the chip is selected. That edge loads the external address. On each later cycle in which the advance input is active, an internal 2-bit beat counter moves on. The counter steps the two low address bits in either linear or interleaved order, and the upper bits stay fixed. A new external address can be loaded on any cycle, so the burst feature is optional.

Writes are sampled in the same cycle as the address. A write can be a byte-masked write, qualified by a byte-write enable, or a global write that stores every byte. Read data leaves through one of two paths, selected by a mode input. In flow-through mode the data comes straight from the array's read register. In pipelined mode it passes through one more rising-edge register. The first access of a burst therefore costs two or three cycles, and every further beat costs one.

There are three chip selects. A sleep input blocks new accesses and keeps the stored contents. An output-enable input gates the output-drive indication combinationally.

Top module: `sram_burst`

## Requirements
- R1: After reset, `rdata_vld_o` and `out_en_o` are low until a read access is made.
- R2: The chip is selected when `ce1_n_i` is low, `ce2_i` is high and `ce3_n_i` is low. With the chip selected, an active processor strobe loads `addr_i` and always starts a read, ignoring the write controls. An active controller strobe, when the processor strobe is not accepted, loads `addr_i` and starts a write if the write controls request one, and a read otherwise.
- R3: The processor strobe is ignored while `ce1_n_i` is high. An ongoing burst then continues as if the strobe were absent.
- R4: In a burst, a cycle with `adv_n_i` low steps the 2-bit beat counter by one, modulo 4. A cycle with `adv_n_i` high repeats the current address. Address bits above bit 1 keep the loaded value.
- R5: With `order_lin_i` = 1 the low two address bits equal (start + beat) mod 4.
- R6: With `order_lin_i` = 0 (interleaved) the low two address bits equal start XOR beat.
- R7: With `gwe_n_i` high and `bwe_n_i` low, only the bytes whose `byte_we_n_i[i]` is low are written. Byte i occupies data bits [i*8+7 : i*8] for 8-bit bytes. If no byte strobe is low, the access is a read.
- R8: With `gwe_n_i` low, every byte is written, whatever `bwe_n_i` and `byte_we_n_i` are.
- R9: With `pipe_mode_i` = 0, read data for an access sampled at edge k is on `rdata_o`, with `rdata_vld_o` high, from edge k until edge k+1.
- R10: With `pipe_mode_i` = 1, the same data and valid appear one clock later, from edge k+1.
- R11: A strobe accepted while the chip is deselected ends the burst. Valid falls after edge k in flow-through mode and after edge k+1 in pipelined mode. Later advance cycles make no access.
- R12: While `sleep_i` is high, `out_en_o` is low at once and the edge makes no read or write. The stored data is kept.
- R13: `out_en_o` is low whenever `oe_n_i` is high. It is high when `oe_n_i` is low, `sleep_i` is low and `rdata_vld_o` is high, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | BYTES*BYTE_W | Write data, sampled with the address |
| cpu_stb_n_i | input | 1 | Processor-side address strobe, active low |
| ctl_stb_n_i | input | 1 | Controller-side address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| ce1_n_i | input | 1 | Chip select 1, active low (also qualifies the processor strobe) |
| ce2_i | input | 1 | Chip select 2, active high |
| ce3_n_i | input | 1 | Chip select 3, active low |
| byte_we_n_i | input | BYTES | Per-byte write strobes, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| gwe_n_i | input | 1 | Global write, active low |
| order_lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| pipe_mode_i | input | 1 | Read path: 1 pipelined, 0 flow-through |
| sleep_i | input | 1 | Sleep, active high |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| rdata_o | output | BYTES*BYTE_W | Read data |
| rdata_vld_o | output | 1 | Read data on `rdata_o` is valid |
| out_en_o | output | 1 | Output would be driven onto a shared bus |

## Verification
The bench builds the block with a 6-bit address and four 8-bit bytes. The bench's reference memory can then shadow the whole array, and four upper address bits sit above the beat counter, so a wrong carry into them shows up as wrong data. Bursts start from several low-bit offsets in both orders and both output modes. This reaches the mod-4 wrap, the XOR pattern, suspended beats and the one-cycle difference in deselect timing between the two paths.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

   localparam int BURST_W   = 2;
   localparam int BURST_LEN = 1 << BURST_W;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

endpackage

// File: rtl/sram_burst_order.sv
// Beat-to-address mapping for the low burst bits.
module sram_burst_order #(
   parameter int CNT_W = 2
) (
   input  logic [CNT_W-1:0] start_i,
   input  logic [CNT_W-1:0] beat_i,
   input  logic             linear_i,
   output logic [CNT_W-1:0] low_o
);
   logic [CNT_W-1:0] lin_low;
   logic [CNT_W-1:0] xor_low;

   always_comb begin
      lin_low = CNT_W'(start_i + beat_i);
      xor_low = start_i ^ beat_i;
      low_o   = linear_i ? lin_low : xor_low;
   end
endmodule

// File: rtl/sram_burst_ctrl.sv
// Strobe decode, chip select, burst base and beat counter.
module sram_burst_ctrl
   import sram_burst_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              cpu_stb_n_i,
   input  logic              ctl_stb_n_i,
   input  logic              adv_n_i,
   input  logic              ce1_n_i,
   input  logic              ce2_i,
   input  logic              ce3_n_i,
   input  logic              sleep_i,
   input  logic              wr_req_i,
   input  logic              order_lin_i,
   output op_e               op_o,
   output logic [ADDR_W-1:0] acc_addr_o,
   output logic              act_o,
   output logic [BURST_W-1:0] cnt_o
);
   logic               act_q, act_d;
   logic [ADDR_W-1:0]  base_q, base_d;
   logic [BURST_W-1:0] cnt_q, cnt_d;
   logic [BURST_W-1:0] cnt_eff;
   logic [BURST_W-1:0] low_bits;
   logic               chip_sel, cpu_go, ctl_go;

   sram_burst_order #(.CNT_W(BURST_W)) u_order (
      .start_i  (base_q[BURST_W-1:0]),
      .beat_i   (cnt_eff),
      .linear_i (order_lin_i),
      .low_o    (low_bits)
   );

   always_comb begin
      chip_sel = !ce1_n_i && ce2_i && !ce3_n_i;
      cpu_go   = !cpu_stb_n_i && !ce1_n_i;
      ctl_go   = !ctl_stb_n_i;
      cnt_eff  = adv_n_i ? cnt_q : BURST_W'(cnt_q + 1'b1);

      op_o       = OP_IDLE;
      act_d      = act_q;
      base_d     = base_q;
      cnt_d      = cnt_q;
      acc_addr_o = {base_q[ADDR_W-1:BURST_W], low_bits};

      if (sleep_i) begin
         act_d = 1'b0;
      end else if (cpu_go || ctl_go) begin
         if (chip_sel) begin
            act_d      = 1'b1;
            base_d     = addr_i;
            cnt_d      = '0;
            acc_addr_o = addr_i;
            op_o       = (!cpu_go && wr_req_i) ? OP_WRITE : OP_READ;
         end else begin
            act_d = 1'b0;
         end
      end else if (act_q) begin
         cnt_d = cnt_eff;
         op_o  = wr_req_i ? OP_WRITE : OP_READ;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         base_q <= '0;
         cnt_q  <= '0;
      end else begin
         act_q  <= act_d;
         base_q <= base_d;
         cnt_q  <= cnt_d;
      end
   end

   assign act_o = act_q;
   assign cnt_o = cnt_q;
endmodule

// File: rtl/sram_burst_array.sv
// Byte-sliced storage with a registered synchronous read.
module sram_burst_array
   import sram_burst_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  op_e                     op_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [BYTES*BYTE_W-1:0] wdata_i,
   input  logic [BYTES-1:0]        wmask_i,
   output logic [BYTES*BYTE_W-1:0] rdata_o,
   output logic                    rvld_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic rvld_q;

   for (genvar b = 0; b < BYTES; b++) begin : g_bank
      logic [BYTE_W-1:0] bank_q [DEPTH];
      logic [BYTE_W-1:0] rd_q;

      always_ff @(posedge clk) begin
         if (op_i == OP_WRITE && wmask_i[b])
            bank_q[addr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
         if (op_i == OP_READ)
            rd_q <= bank_q[addr_i];
      end

      assign rdata_o[b*BYTE_W +: BYTE_W] = rd_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rvld_q <= 1'b0;
      else        rvld_q <= (op_i == OP_READ);
   end

   assign rvld_o = rvld_q;
endmodule

// File: rtl/sram_burst_outpath.sv
// Flow-through or registered read output, plus drive gating.
module sram_burst_outpath #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_mode_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              rd_vld_i,
   input  logic              oe_n_i,
   input  logic              sleep_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rdata_vld_o,
   output logic              out_en_o,
   output logic              pipe_vld_o
);
   logic [DATA_W-1:0] pipe_data_q;
   logic              pipe_vld_q;

   always_ff @(posedge clk) pipe_data_q <= rd_data_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_vld_q <= 1'b0;
      else        pipe_vld_q <= rd_vld_i;
   end

   always_comb begin
      rdata_o     = pipe_mode_i ? pipe_data_q : rd_data_i;
      rdata_vld_o = pipe_mode_i ? pipe_vld_q  : rd_vld_i;
      out_en_o    = rdata_vld_o && !oe_n_i && !sleep_i;
   end

   assign pipe_vld_o = pipe_vld_q;
endmodule

// File: rtl/sram_burst.sv
module sram_burst
   import sram_burst_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [BYTES*BYTE_W-1:0] wdata_i,
   input  logic                    cpu_stb_n_i,
   input  logic                    ctl_stb_n_i,
   input  logic                    adv_n_i,
   input  logic                    ce1_n_i,
   input  logic                    ce2_i,
   input  logic                    ce3_n_i,
   input  logic [BYTES-1:0]        byte_we_n_i,
   input  logic                    bwe_n_i,
   input  logic                    gwe_n_i,
   input  logic                    order_lin_i,
   input  logic                    pipe_mode_i,
   input  logic                    sleep_i,
   input  logic                    oe_n_i,
   output logic [BYTES*BYTE_W-1:0] rdata_o,
   output logic                    rdata_vld_o,
   output logic                    out_en_o
);
   localparam int DATA_W = BYTES * BYTE_W;

   if (ADDR_W <= BURST_W) begin : g_bad_addr
      $error("sram_burst: ADDR_W must exceed the burst counter width");
   end
   if (BYTES < 1) begin : g_bad_bytes
      $error("sram_burst: BYTES must be at least 1");
   end
   if (BYTE_W < 1) begin : g_bad_byte_w
      $error("sram_burst: BYTE_W must be at least 1");
   end

   logic [BYTES-1:0]   wr_mask;
   logic               wr_req;
   op_e                acc_op;
   logic [ADDR_W-1:0]  acc_addr;
   logic               burst_act;
   logic [BURST_W-1:0] burst_cnt;
   logic [DATA_W-1:0]  arr_data;
   logic               arr_vld;
   logic               pipe_vld;

   for (genvar b = 0; b < BYTES; b++) begin : g_mask
      assign wr_mask[b] = !gwe_n_i || (!bwe_n_i && !byte_we_n_i[b]);
   end
   assign wr_req = |wr_mask;

   sram_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_i      (addr_i),
      .cpu_stb_n_i (cpu_stb_n_i),
      .ctl_stb_n_i (ctl_stb_n_i),
      .adv_n_i     (adv_n_i),
      .ce1_n_i     (ce1_n_i),
      .ce2_i       (ce2_i),
      .ce3_n_i     (ce3_n_i),
      .sleep_i     (sleep_i),
      .wr_req_i    (wr_req),
      .order_lin_i (order_lin_i),
      .op_o        (acc_op),
      .acc_addr_o  (acc_addr),
      .act_o       (burst_act),
      .cnt_o       (burst_cnt)
   );

   sram_burst_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_i    (acc_op),
      .addr_i  (acc_addr),
      .wdata_i (wdata_i),
      .wmask_i (wr_mask),
      .rdata_o (arr_data),
      .rvld_o  (arr_vld)
   );

   sram_burst_outpath #(.DATA_W(DATA_W)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .pipe_mode_i (pipe_mode_i),
      .rd_data_i   (arr_data),
      .rd_vld_i    (arr_vld),
      .oe_n_i      (oe_n_i),
      .sleep_i     (sleep_i),
      .rdata_o     (rdata_o),
      .rdata_vld_o (rdata_vld_o),
      .out_en_o    (out_en_o),
      .pipe_vld_o  (pipe_vld)
   );
endmodule

// File: rtl/sram_burst_chk.sv
module sram_burst_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_stb_n_i,
   input logic       ctl_stb_n_i,
   input logic       adv_n_i,
   input logic       ce1_n_i,
   input logic       ce2_i,
   input logic       ce3_n_i,
   input logic       sleep_i,
   input logic       oe_n_i,
   input logic       rdata_vld_o,
   input logic       out_en_o,
   input logic       burst_act,
   input logic [1:0] burst_cnt,
   input logic       arr_vld,
   input logic       pipe_vld
);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!rdata_vld_o && !out_en_o));

   assert_cpu_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_stb_n_i && !ce1_n_i && ce2_i && !ce3_n_i && !sleep_i) |=> arr_vld);

   assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_act && cpu_stb_n_i && ctl_stb_n_i && adv_n_i && !sleep_i)
      |=> $stable(burst_cnt));

   assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_act && cpu_stb_n_i && ctl_stb_n_i && !adv_n_i && !sleep_i)
      |=> (burst_cnt == 2'($past(burst_cnt) + 2'd1)));

   assert_pipe_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      arr_vld |=> pipe_vld);

   assert_pipe_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !arr_vld |=> !pipe_vld);

   assert_deselect_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ce3_n_i && (!ctl_stb_n_i || (!cpu_stb_n_i && !ce1_n_i))) |=> !burst_act);

   assert_sleep_noacc_R12: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |=> (!arr_vld && !burst_act));

   assert_sleep_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |-> !out_en_o);

   assert_oe_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n_i |-> !out_en_o);
endmodule

bind sram_burst sram_burst_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_stb_n_i (cpu_stb_n_i),
   .ctl_stb_n_i (ctl_stb_n_i),
   .adv_n_i     (adv_n_i),
   .ce1_n_i     (ce1_n_i),
   .ce2_i       (ce2_i),
   .ce3_n_i     (ce3_n_i),
   .sleep_i     (sleep_i),
   .oe_n_i      (oe_n_i),
   .rdata_vld_o (rdata_vld_o),
   .out_en_o    (out_en_o),
   .burst_act   (burst_act),
   .burst_cnt   (burst_cnt),
   .arr_vld     (arr_vld),
   .pipe_vld    (pipe_vld)
);

// File: tb/sram_burst_tb_top.sv
`timescale 1ns/1ps
module sram_burst_tb_top;
   localparam int AW = 6;
   localparam int NB = 4;
   localparam int BW = 8;
   localparam int DW = NB * BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] wdata_i = '0;
   logic          cpu_stb_n_i = 1'b1, ctl_stb_n_i = 1'b1, adv_n_i = 1'b1;
   logic          ce1_n_i = 1'b0, ce2_i = 1'b1, ce3_n_i = 1'b0;
   logic [NB-1:0] byte_we_n_i = '1;
   logic          bwe_n_i = 1'b1, gwe_n_i = 1'b1;
   logic          order_lin_i = 1'b0, pipe_mode_i = 1'b1;
   logic          sleep_i = 1'b0, oe_n_i = 1'b0;
   logic [DW-1:0] rdata_o;
   logic          rdata_vld_o, out_en_o;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] model [1 << AW];

   always #5 clk = ~clk;

   sram_burst #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
      .cpu_stb_n_i(cpu_stb_n_i), .ctl_stb_n_i(ctl_stb_n_i), .adv_n_i(adv_n_i),
      .ce1_n_i(ce1_n_i), .ce2_i(ce2_i), .ce3_n_i(ce3_n_i),
      .byte_we_n_i(byte_we_n_i), .bwe_n_i(bwe_n_i), .gwe_n_i(gwe_n_i),
      .order_lin_i(order_lin_i), .pipe_mode_i(pipe_mode_i), .sleep_i(sleep_i),
      .oe_n_i(oe_n_i), .rdata_o(rdata_o), .rdata_vld_o(rdata_vld_o),
      .out_en_o(out_en_o)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      cpu_stb_n_i = 1'b1; ctl_stb_n_i = 1'b1; adv_n_i = 1'b1;
      ce1_n_i = 1'b0; ce2_i = 1'b1; ce3_n_i = 1'b0;
      byte_we_n_i = '1; bwe_n_i = 1'b1; gwe_n_i = 1'b1;
      sleep_i = 1'b0; oe_n_i = 1'b0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [NB-1:0] mask, input logic global);
      @(negedge clk);
      idle();
      addr_i = a; wdata_i = d; ctl_stb_n_i = 1'b0;
      if (global) gwe_n_i = 1'b0;
      else begin bwe_n_i = 1'b0; byte_we_n_i = ~mask; end
      for (int b = 0; b < NB; b++)
         if (global || mask[b]) model[a][b*BW +: BW] = d[b*BW +: BW];
      @(negedge clk);
      idle();
   endtask

   task automatic desel();
      @(negedge clk);
      idle(); ctl_stb_n_i = 1'b0; ce2_i = 1'b0;
      @(negedge clk);
      idle();
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic rd_flow(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
      @(negedge clk);
      idle(); pipe_mode_i = 1'b0; addr_i = a; cpu_stb_n_i = 1'b0;
      @(negedge clk);
      idle();
      chk(req, rdata_o, exp);
      chk(req, {31'd0, rdata_vld_o}, 32'd1);
   endtask

   task automatic t_reset();
      idle();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", {31'd0, rdata_vld_o}, 32'd0);
      chk("R1 drive after reset", {31'd0, out_en_o}, 32'd0);
   endtask

   task automatic t_preload();
      for (int a = 0; a < 16; a++) wr(6'(a), 32'hA500_0000 + 32'(a) * 32'h0101_0101, '1, 1'b1);
      wr(6'd40, 32'hDEAD_0040, '1, 1'b1);
      rd_flow(6'd9, model[9], "R2 controller write then processor read");
   endtask

   task automatic t_latency(input logic pipe);
      desel();
      pipe_mode_i = pipe;
      @(negedge clk);
      addr_i = 6'd12; cpu_stb_n_i = 1'b0;
      @(negedge clk);
      idle();
      if (pipe) begin
         chk("R10 no data after first edge", {31'd0, rdata_vld_o}, 32'd0);
         @(negedge clk);
         chk("R10 data after second edge", rdata_o, model[12]);
         chk("R10 valid after second edge", {31'd0, rdata_vld_o}, 32'd1);
      end else begin
         chk("R9 data after first edge", rdata_o, model[12]);
         chk("R9 valid after first edge", {31'd0, rdata_vld_o}, 32'd1);
      end
   endtask

   task automatic burst(input logic [AW-1:0] start, input logic lin, input logic pipe,
                        input int hold_at, input string req);
      logic [AW-1:0] exp_a [4];
      logic [1:0] c;
      c = 2'd0;
      for (int j = 0; j < 4; j++) begin
         if (j != 0 && j != hold_at) c = c + 2'd1;
         exp_a[j] = {start[AW-1:2], lin ? 2'(start[1:0] + c) : (start[1:0] ^ c)};
      end
      desel();
      order_lin_i = lin; pipe_mode_i = pipe;
      @(negedge clk);
      addr_i = start; cpu_stb_n_i = 1'b0;
      for (int n = 1; n <= 4 + int'(pipe); n++) begin
         @(negedge clk);
         idle();
         if (n - 1 - int'(pipe) >= 0) begin
            chk(req, rdata_o, model[exp_a[n - 1 - int'(pipe)]]);
            chk(req, {31'd0, rdata_vld_o}, 32'd1);
         end
         if (n <= 3 && n != hold_at) adv_n_i = 1'b0;
      end
   endtask

   task automatic t_cpu_ignored();
      desel();
      order_lin_i = 1'b1; pipe_mode_i = 1'b0;
      @(negedge clk);
      addr_i = 6'd9; cpu_stb_n_i = 1'b0;
      @(negedge clk);
      idle();
      chk("R3 burst start", rdata_o, model[9]);
      addr_i = 6'd40; cpu_stb_n_i = 1'b0; ce1_n_i = 1'b1; adv_n_i = 1'b0;
      @(negedge clk);
      idle();
      chk("R3 strobe ignored, burst advanced", rdata_o, model[10]);
      desel();
      @(negedge clk);
      addr_i = 6'd40; cpu_stb_n_i = 1'b0; ce1_n_i = 1'b1;
      @(negedge clk);
      idle();
      chk("R3 no access when idle", {31'd0, rdata_vld_o}, 32'd0);
   endtask

   task automatic t_deselect();
      desel();
      pipe_mode_i = 1'b0;
      @(negedge clk);
      addr_i = 6'd8; cpu_stb_n_i = 1'b0;
      @(negedge clk);
      idle();
      chk("R11 flow burst live", {31'd0, rdata_vld_o}, 32'd1);
      ctl_stb_n_i = 1'b0; ce2_i = 1'b0;
      @(negedge clk);
      idle();
      chk("R11 flow valid drops", {31'd0, rdata_vld_o}, 32'd0);
      adv_n_i = 1'b0;
      @(negedge clk);
      idle();
      chk("R11 advance after deselect", {31'd0, rdata_vld_o}, 32'd0);
      desel();
      pipe_mode_i = 1'b1;
      @(negedge clk);
      addr_i = 6'd8; cpu_stb_n_i = 1'b0;
      @(negedge clk);
      idle();
      @(negedge clk);
      chk("R11 pipe burst live", {31'd0, rdata_vld_o}, 32'd1);
      ctl_stb_n_i = 1'b0; ce3_n_i = 1'b1;
      @(negedge clk);
      idle();
      chk("R11 pipe valid one more cycle", {31'd0, rdata_vld_o}, 32'd1);
      @(negedge clk);
      chk("R11 pipe valid drops", {31'd0, rdata_vld_o}, 32'd0);
   endtask

   task automatic t_bytes();
      wr(6'd5, 32'h1122_3344, '1, 1'b1);
      wr(6'd5, 32'hAABB_CCDD, 4'b0101, 1'b0);
      rd_flow(6'd5, 32'h11BB_33DD, "R7 masked bytes only");
      wr(6'd5, 32'h5566_7788, 4'b0001, 1'b1);
      rd_flow(6'd5, 32'h5566_7788, "R8 global write overrides strobes");
      @(negedge clk);
      idle(); addr_i = 6'd5; wdata_i = 32'h0; ctl_stb_n_i = 1'b0; bwe_n_i = 1'b0;
      @(negedge clk);
      idle();
      chk("R7 no byte strobe gives read", rdata_o, 32'h5566_7788);
      @(negedge clk);
      addr_i = 6'd5; wdata_i = 32'h0; cpu_stb_n_i = 1'b0; gwe_n_i = 1'b0;
      @(negedge clk);
      idle();
      chk("R2 processor strobe reads despite write", rdata_o, 32'h5566_7788);
      rd_flow(6'd5, 32'h5566_7788, "R2 memory unchanged");
   endtask

   task automatic t_sleep();
      wr(6'd20, 32'hCAFE_0020, '1, 1'b1);
      rd_flow(6'd20, 32'hCAFE_0020, "R12 setup read");
      @(negedge clk);
      idle(); sleep_i = 1'b1;
      addr_i = 6'd20; wdata_i = 32'hDEAD_BEEF; ctl_stb_n_i = 1'b0; gwe_n_i = 1'b0;
      #1;
      chk("R12 drive off at once", {31'd0, out_en_o}, 32'd0);
      @(negedge clk);
      chk("R12 no access in sleep", {31'd0, rdata_vld_o}, 32'd0);
      idle();
      rd_flow(6'd20, 32'hCAFE_0020, "R12 data retained");
   endtask

   task automatic t_oe();
      rd_flow(6'd3, model[3], "R13 setup read");
      chk("R13 drive on", {31'd0, out_en_o}, 32'd1);
      oe_n_i = 1'b1;
      #1;
      chk("R13 drive off without edge", {31'd0, out_en_o}, 32'd0);
      oe_n_i = 1'b0;
      #1;
      chk("R13 drive back on", {31'd0, out_en_o}, 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_preload();
      t_latency(1'b0);
      t_latency(1'b1);
      burst(6'd9,  1'b1, 1'b0, -1, "R5 linear from 1 flow");
      burst(6'd11, 1'b1, 1'b1, -1, "R5 linear from 3 pipe");
      burst(6'd9,  1'b0, 1'b0, -1, "R6 interleaved from 1 flow");
      burst(6'd14, 1'b0, 1'b1, -1, "R6 interleaved from 2 pipe");
      burst(6'd9,  1'b1, 1'b0, 2,  "R4 suspended beat repeats");
      t_cpu_ignored();
      t_deselect();
      t_bytes();
      t_sleep();
      t_oe();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule